// File: doc/BRIEF.md
# Transmit Byte Queue with NAK Hold

This block sits between a register-level data port and the byte engine of a two-wire serial bus master. While the queue is switched on, every write to the data port appends one byte to a 64-entry first-in first-out store instead of going to the bus at once. The head byte is offered to the byte engine through a valid/ready handshake, and the engine takes bytes one at a time.

The byte engine reports the outcome of each byte on a result strobe. If a target answers with a not-acknowledge, the queue stops offering bytes. The bytes still stored stay in place until software writes the flush bit. Two sticky interrupt causes, "queue became empty" and "not-acknowledge seen", each have their own mask bit and are cleared by writing ones. A separate status byte shows whether the queue is empty.

Top module: `txq_nak_fifo`

## Requirements
- R1: After reset the queue is empty (`fifo_stat` bit 4 = 1, all other bits 0), `isr_rdata` = 0, `ack_flag` = 0, `irq` = 0, `eng_valid` = 0, and the queue is switched off.
- R2: A control write with bit 6 = 1 switches the queue on. While it is on and not halted, data writes are appended, and the engine receives bytes in write order, one per cycle with `eng_valid` and `eng_ready` both high. `eng_valid` is high exactly when the queue is on, not halted and not empty.
- R3: A control write with bit 6 = 0 switches the queue off. While it is off, data writes are not stored and `eng_valid` stays low.
- R4: The queue holds 64 bytes. A data write to a full queue is dropped, and the queue later drains exactly the first 64 bytes.
- R5: A control write with bit 7 = 1 discards all stored bytes. Writing 0xC0 flushes the queue and leaves it on. A data write in the same cycle as a flush is not stored.
- R6: A data write and an engine take in the same cycle leave the occupancy unchanged and keep byte order.
- R7: `isr_rdata` bit 1 is set when an engine take leaves the queue empty. A flush does not set it.
- R8: A result strobe with `eng_nak` = 1 sets `isr_rdata` bit 0 and `ack_flag`, and stops draining with the remaining bytes held. A flush clears `ack_flag` and resumes draining.
- R9: Interrupt status bits are sticky and are cleared by writing 1 to `isr_wdata` with `isr_wr`. A set event in the same cycle as a clear wins. Bits 7:2 read as 0.
- R10: `irq` is high exactly when some status bit and the matching mask bit, written through `ier_wdata` bits 1:0, are both 1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data, bit 7 = flush, bit 6 = enable |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Byte to enqueue |
| ier_wr | input | 1 | Interrupt mask write strobe |
| ier_wdata | input | 2 | Mask bits, bit 1 = empty cause, bit 0 = NAK cause |
| isr_wr | input | 1 | Interrupt status clear strobe |
| isr_wdata | input | 2 | Write-1-to-clear bits for the status |
| isr_rdata | output | 8 | Interrupt status, bit 1 = became empty, bit 0 = NAK |
| fifo_stat | output | 8 | Queue status, bit 4 = empty |
| ack_flag | output | 1 | High after a NAK until the next flush |
| irq | output | 1 | Masked interrupt request |
| eng_valid | output | 1 | Head byte offered to the byte engine |
| eng_data | output | 8 | Head byte |
| eng_ready | input | 1 | Byte engine takes the head byte |
| eng_res | input | 1 | Byte engine result strobe |
| eng_nak | input | 1 | Result was a not-acknowledge |

## Verification
Two pairs of functions can fall in the same cycle. An append can meet an engine take, and a status set can meet a write-1 clear of the same bit. Both pairs are provoked by directed cycles: one appends while the engine takes with exactly one byte stored, and one pops the last byte while the empty bit is cleared. Long random runs also mix data writes, takes, flushes, NAK strobes and clears. Every cycle is judged against a queue model in the bench that follows the stated priority: the set wins over the clear, and the occupancy and byte order survive a simultaneous append and take.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int BYTE_W         = 8;
    localparam int CTL_FLUSH_BIT  = 7;
    localparam int CTL_EN_BIT     = 6;
    localparam int STAT_EMPTY_BIT = 4;

    // Interrupt cause vector: bit 1 = became empty, bit 0 = NAK
    typedef struct packed {
        logic empty;
        logic nak;
    } txq_evt_t;

    typedef struct packed {
        logic flush;
        logic enable;
        logic wr;
    } txq_cmd_t;

    function automatic txq_cmd_t decode_ctl(input logic wr, input logic [7:6] d);
        txq_cmd_t c;
        c.wr     = wr;
        c.flush  = wr & d[CTL_FLUSH_BIT];
        c.enable = d[CTL_EN_BIT];
        return c;
    endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          drained,
    output logic [CW-1:0] occ
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign head    = mem[rd_ptr];
    assign occ     = cnt;
    assign drained = pop && !push && !flush && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/txq_drain.sv
module txq_drain
    import txq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  txq_cmd_t cmd,
    input  logic     dat_wr,
    input  logic     full,
    input  logic     empty,
    input  logic     eng_ready,
    input  logic     nak_evt,
    output logic     push,
    output logic     pop,
    output logic     valid,
    output logic     halted
);
    logic en_q, halt_q;

    assign valid  = en_q && !halt_q && !empty;
    assign pop    = valid && eng_ready;
    assign push   = dat_wr && en_q && !cmd.flush && !full;
    assign halted = halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            if (cmd.wr) en_q <= cmd.enable;
            if (cmd.flush)  halt_q <= 1'b0;
            else if (nak_evt) halt_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txq_irq.sv
module txq_irq
    import txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  txq_evt_t   set_evt,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       mask_wr,
    input  logic [1:0] mask_bits,
    output txq_evt_t   status,
    output logic       irq
);
    txq_evt_t st_q;
    logic [1:0] mask_q;
    logic [1:0] clr;

    assign clr    = clr_wr ? clr_bits : 2'b00;
    assign status = st_q;
    assign irq    = |(st_q & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            mask_q <= '0;
        end else begin
            st_q <= (st_q & ~clr) | set_evt;
            if (mask_wr) mask_q <= mask_bits;
        end
    end
endmodule

// File: rtl/txq_nak_fifo.sv
module txq_nak_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = BYTE_W,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic [7:6]   ctl_wdata,
    input  logic         dat_wr,
    input  logic [W-1:0] dat_wdata,
    input  logic         ier_wr,
    input  logic [1:0]   ier_wdata,
    input  logic         isr_wr,
    input  logic [1:0]   isr_wdata,
    output logic [7:0]   isr_rdata,
    output logic [7:0]   fifo_stat,
    output logic         ack_flag,
    output logic         irq,
    output logic         eng_valid,
    output logic [W-1:0] eng_data,
    input  logic         eng_ready,
    input  logic         eng_res,
    input  logic         eng_nak
);
    txq_cmd_t      cmd;
    txq_evt_t      evt, status;
    logic          push, pop, empty, full, drained, halted;
    logic [CW-1:0] occ;

    assign cmd       = decode_ctl(ctl_wr, ctl_wdata);
    assign evt.empty = drained;
    assign evt.nak   = eng_res && eng_nak;

    txq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(cmd.flush),
        .wdata(dat_wdata), .head(eng_data), .empty(empty), .full(full),
        .drained(drained), .occ(occ)
    );

    txq_drain u_drain (
        .clk(clk), .rst(rst), .cmd(cmd), .dat_wr(dat_wr), .full(full),
        .empty(empty), .eng_ready(eng_ready), .nak_evt(evt.nak),
        .push(push), .pop(pop), .valid(eng_valid), .halted(halted)
    );

    txq_irq u_irq (
        .clk(clk), .rst(rst), .set_evt(evt), .clr_wr(isr_wr),
        .clr_bits(isr_wdata), .mask_wr(ier_wr), .mask_bits(ier_wdata),
        .status(status), .irq(irq)
    );

    assign isr_rdata = {6'b0, status};
    assign ack_flag  = halted;

    always_comb begin
        fifo_stat = '0;
        fifo_stat[STAT_EMPTY_BIT] = empty;
    end
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_wr,
    input logic [7:6]    ctl_wdata,
    input logic          ier_wr,
    input logic [1:0]    ier_wdata,
    input logic [7:0]    isr_rdata,
    input logic [7:0]    fifo_stat,
    input logic          eng_valid,
    input logic          eng_res,
    input logic          eng_nak,
    input logic          irq,
    input logic [CW-1:0] occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH)); // R4
    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> !fifo_stat[4]); // R2
    AST_OFF_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[6]) |=> !eng_valid); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[7]) |=> fifo_stat[4]); // R5
    AST_NAK_STOPS: assert property (@(posedge clk) disable iff (rst)
        (eng_res && eng_nak && !(ctl_wr && ctl_wdata[7])) |=> !eng_valid); // R8
    AST_NAK_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (eng_res && eng_nak) |=> isr_rdata[0]); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        isr_rdata[7:2] == 6'd0); // R9
    AST_MASK_OFF: assert property (@(posedge clk) disable iff (rst)
        (ier_wr && ier_wdata == 2'b00) |=> !irq); // R10
endmodule

bind txq_nak_fifo txq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .isr_rdata(isr_rdata),
    .fifo_stat(fifo_stat), .eng_valid(eng_valid), .eng_res(eng_res),
    .eng_nak(eng_nak), .irq(irq), .occ(occ)
);

// File: tb/sim_txq_nak_fifo.sv
module sim_txq_nak_fifo;
    localparam int DEPTH = 64;

    logic clk = 0, rst = 1;
    logic ctl_wr = 0, dat_wr = 0, ier_wr = 0, isr_wr = 0;
    logic [7:6] ctl_wdata = 0;
    logic [7:0] dat_wdata = 0;
    logic [1:0] ier_wdata = 0, isr_wdata = 0;
    logic eng_ready = 0, eng_res = 0, eng_nak = 0;
    logic [7:0] isr_rdata, fifo_stat, eng_data;
    logic ack_flag, irq, eng_valid;

    int total = 0, bad = 0;
    logic [7:0] mq[$];
    logic m_en = 0, m_halt = 0;
    logic [1:0] m_isr = 0, m_ier = 0;

    always #5 clk = ~clk;

    txq_nak_fifo #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .ier_wr(ier_wr),
        .ier_wdata(ier_wdata), .isr_wr(isr_wr), .isr_wdata(isr_wdata),
        .isr_rdata(isr_rdata), .fifo_stat(fifo_stat), .ack_flag(ack_flag),
        .irq(irq), .eng_valid(eng_valid), .eng_data(eng_data),
        .eng_ready(eng_ready), .eng_res(eng_res), .eng_nak(eng_nak)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_valid();
        return m_en && !m_halt && (mq.size() > 0);
    endfunction

    task automatic idle();
        ctl_wr = 0; dat_wr = 0; ier_wr = 0; isr_wr = 0;
        eng_ready = 0; eng_res = 0; eng_nak = 0;
    endtask

    // Compare every output with the model, then advance one clock
    task automatic cycle(input string tag);
        logic f, p, pu, be;
        int sz;
        sz = mq.size();
        chk({tag, " eng_valid"}, eng_valid, exp_valid());
        if (exp_valid()) chk({tag, " eng_data"}, eng_data, mq[0]);
        chk({tag, " fifo_stat"}, fifo_stat, (sz == 0) ? 8'h10 : 8'h00);
        chk({tag, " isr"}, isr_rdata, {6'b0, m_isr});
        chk({tag, " ack_flag"}, ack_flag, m_halt);
        chk({tag, " irq"}, irq, |(m_isr & m_ier));
        f  = ctl_wr && ctl_wdata[7];
        p  = exp_valid() && eng_ready;
        pu = dat_wr && m_en && !f && (sz < DEPTH);
        be = p && !pu && !f && (sz == 1);
        if (f) mq.delete();
        else begin
            if (p)  void'(mq.pop_front());
            if (pu) mq.push_back(dat_wdata);
        end
        m_isr = (m_isr & ~(isr_wr ? isr_wdata : 2'b00)) | {be, eng_res && eng_nak};
        if (ier_wr) m_ier = ier_wdata;
        if (f) m_halt = 0;
        else if (eng_res && eng_nak) m_halt = 1;
        if (ctl_wr) m_en = ctl_wdata[6];
        @(posedge clk); #1;
        idle();
    endtask

    task automatic ctl(input logic [7:6] v, input string tag);
        ctl_wr = 1; ctl_wdata = v; cycle(tag);
    endtask

    task automatic put(input logic [7:0] b, input string tag);
        dat_wr = 1; dat_wdata = b; cycle(tag);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 fifo_stat", fifo_stat, 8'h10);
        chk("R1 isr", isr_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 ack_flag", ack_flag, 1'b0);
        chk("R1 eng_valid", eng_valid, 1'b0);

        // R3: writes while switched off are not stored
        put(8'hA1, "R3");
        put(8'hA2, "R3");
        chk("R3 still empty", fifo_stat, 8'h10);

        // R2 enable, enqueue, drain in order
        ctl(2'b01, "R2");
        for (int i = 0; i < 5; i++) put(8'h10 + 8'(i), "R2");
        for (int i = 0; i < 5; i++) begin eng_ready = 1; cycle("R2 drain"); end
        cycle("R2");

        // R7 empty cause with mask, R9 clear
        chk("R7 empty cause", isr_rdata, 8'h02);
        ier_wr = 1; ier_wdata = 2'b10; cycle("R10");
        chk("R10 irq", irq, 1'b1);
        isr_wr = 1; isr_wdata = 2'b10; cycle("R9 clear");
        chk("R9 cleared", isr_rdata, 8'h00);

        // R4 fill past depth then drain
        for (int i = 0; i < DEPTH + 1; i++) put(8'(i * 3 + 1), "R4 fill");
        chk("R4 full holds 64", mq.size(), 64);
        for (int i = 0; i < DEPTH; i++) begin eng_ready = 1; cycle("R4 drain"); end
        cycle("R4 empty after 64");

        // R6 push and take in the same cycle, one byte stored
        put(8'h55, "R6");
        dat_wr = 1; dat_wdata = 8'h66; eng_ready = 1; cycle("R6 both");
        chk("R6 head", eng_data, 8'h66);
        chk("R6 not empty", fifo_stat, 8'h00);

        // R9 set wins over clear on the same cycle
        isr_wr = 1; isr_wdata = 2'b11; eng_ready = 1; cycle("R9 set wins");
        chk("R9 set kept", isr_rdata[1], 1'b1);

        // R8 NAK halts, holds bytes, flush recovers
        for (int i = 0; i < 4; i++) put(8'hC0 + 8'(i), "R8 load");
        eng_ready = 1; cycle("R8 take");
        eng_res = 1; eng_nak = 1; eng_ready = 1; cycle("R8 nak");
        chk("R8 halted", eng_valid, 1'b0);
        chk("R8 ack_flag", ack_flag, 1'b1);
        cycle("R8 held");
        chk("R8 bytes held", fifo_stat, 8'h00);

        // R5 flush with enable kept, push in flush cycle dropped
        ctl_wr = 1; ctl_wdata = 2'b11; dat_wr = 1; dat_wdata = 8'hEE; cycle("R5 flush");
        chk("R5 empty", fifo_stat, 8'h10);
        chk("R8 ack cleared", ack_flag, 1'b0);
        put(8'h77, "R5 still on");
        chk("R5 head", eng_data, 8'h77);
        isr_wr = 1; isr_wdata = 2'b11; cycle("R9");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            dat_wr    = ($urandom_range(0, 99) < 55);
            dat_wdata = 8'($urandom);
            eng_ready = ($urandom_range(0, 99) < 45);
            if (r < 2) begin eng_res = 1; eng_nak = 1; end
            else if (r < 10) begin eng_res = 1; eng_nak = 0; end
            else if (r < 14) begin ctl_wr = 1; ctl_wdata = 2'b11; end
            else if (r < 15) begin ctl_wr = 1; ctl_wdata = 2'b00; end
            else if (r < 17) begin ctl_wr = 1; ctl_wdata = 2'b01; end
            if ($urandom_range(0, 99) < 8) begin isr_wr = 1; isr_wdata = 2'($urandom); end
            if ($urandom_range(0, 99) < 5) begin ier_wr = 1; ier_wdata = 2'($urandom); end
            cycle("R2 R6 R7 R8 R9 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule